// File: doc/BRIEF.md
# Internal Clock Source Selector with Table Divider

This block drives six consumer clock-enable strobes. A strobe-based design keeps the whole chip in one system clock, and a "clock" is a one-cycle pulse on an enable line. Each consumer owns a 5-bit field of a single 32-bit configuration word. The field picks one of seven input strobes: the auxiliary PLL strobe or one of six frequency-generator strobes. It also picks an entry in a small divide table. The block counts the selected pulses and issues one consumer pulse for every N input pulses.

A source code of zero turns the consumer off. A variant input selects one of two divide tables, and the alternate table adds a divide-by-3. Software-visible state is limited to the configuration word, which is written and read through a plain word port.

Top module: `intsrc_clock_sel`

## Requirements
- R1: Consumer i (i = 0..5) is configured by configuration bits [5*i+4 : 5*i]. Writing a field affects only that consumer.
- R2: Field bits [4:2] hold the source code. Code 1 selects `auxStrobe`, and codes 2..7 select `genStrobe[0]`..`genStrobe[5]`.
- R3: With `altTable` low, field bits [1:0] = 0, 1, 2, 3 give divide-by 1, 4, 1, 2.
- R4: With `altTable` high, field bits [1:0] = 0, 1, 2, 3 give divide-by 1, 4, 3, 2.
- R5: A consumer is enabled exactly when its source code is nonzero. A disabled consumer keeps its output low.
- R6: Divide-by-1 passes each selected input pulse to the output in the same cycle.
- R7: Divide-by-N emits one output pulse per N selected input pulses. Counting starts afresh after a restart, so the first output coincides with the Nth input pulse.
- R8: A write that changes a consumer's field restarts its count, and so does a change of `altTable`. An input pulse in the cycle of that write or change is not counted.
- R9: `rdData` returns the stored configuration, and bits [31:30] always read as zero.
- R10: After reset the configuration is zero, so every consumer is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Configuration write strobe |
| wrData | input | 32 | Configuration write value |
| rdData | output | 32 | Configuration read value |
| altTable | input | 1 | Selects the alternate divide table |
| auxStrobe | input | 1 | Auxiliary PLL clock strobe |
| genStrobe | input | 6 | Frequency-generator clock strobes |
| consumerStrobe | output | 6 | Divided consumer clock strobes |

## Verification
A configuration write and a pulse of the selected source can land in the same cycle. The restart must then win, so the pulse is not counted toward the new divide. The bench sets up a partial count under one divide ratio, then writes a new ratio while the source pulses. It judges the outcome by the exact number of output pulses that later input pulses produce. A variant-table toggle between pulses is handled the same way, by checking that the partial count it leaves behind does not advance the first output.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;
  localparam int NUM_SLOTS = 6;
  localparam int FIELD_W   = 5;
  localparam int SRC_W     = 3;
  localparam int IDX_W     = 2;
  localparam int CNT_W     = 2;
  localparam int REG_W     = 32;
  localparam int NUM_GEN   = 6;
  localparam int USED_W    = NUM_SLOTS * FIELD_W;
  localparam int NUM_IN    = NUM_GEN + 1;

  typedef struct packed {
    logic             enable;
    logic [SRC_W-1:0] srcCode;
    logic [CNT_W-1:0] lastCount;
    logic             restart;
  } slotCtrl_t;

  // terminal count (divisor - 1) per table index and variant
  function automatic logic [CNT_W-1:0] divLast(input logic [IDX_W-1:0] idx, input logic alt);
    logic [CNT_W-1:0] r;
    case (idx)
      2'd0:    r = 2'd0;
      2'd1:    r = 2'd3;
      2'd2:    r = alt ? 2'd2 : 2'd0;
      default: r = 2'd1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/intsrc_ctrl.sv
module intsrc_ctrl
  import intsrc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [REG_W-1:0]     wrData,
  input  logic                 altTable,
  output logic [USED_W-1:0]    cfgWord,
  output slotCtrl_t [NUM_SLOTS-1:0] slotCtrl
);
  logic [USED_W-1:0] cfgReg;
  logic              altQ;
  logic              altChanged;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
      altQ   <= 1'b0;
    end else begin
      altQ <= altTable;
      if (wrEn) cfgReg <= wrData[USED_W-1:0];
    end
  end

  assign altChanged = (altTable != altQ);
  assign cfgWord    = cfgReg;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [FIELD_W-1:0] curField;
    logic [FIELD_W-1:0] newField;
    logic               fieldChanged;
    assign curField     = cfgReg[FIELD_W*i +: FIELD_W];
    assign newField     = wrData[FIELD_W*i +: FIELD_W];
    assign fieldChanged = wrEn && (newField != curField);
    always_comb begin
      slotCtrl[i].srcCode   = curField[FIELD_W-1:IDX_W];
      slotCtrl[i].enable    = (curField[FIELD_W-1:IDX_W] != '0);
      slotCtrl[i].lastCount = divLast(curField[IDX_W-1:0], altTable);
      slotCtrl[i].restart   = fieldChanged || altChanged;
    end
  end
endmodule

// File: rtl/intsrc_datapath.sv
module intsrc_datapath
  import intsrc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  slotCtrl_t [NUM_SLOTS-1:0] slotCtrl,
  input  logic                      auxStrobe,
  input  logic [NUM_GEN-1:0]        genStrobe,
  output logic [NUM_SLOTS-1:0]      consumerStrobe
);
  logic [NUM_IN-1:0] srcVec;
  assign srcVec = {genStrobe, auxStrobe};

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_lane
    logic             selStrobe;
    logic [CNT_W-1:0] pulseCnt;
    logic             atLast;

    always_comb begin
      selStrobe = 1'b0;
      for (int s = 1; s <= NUM_IN; s++) begin
        if (int'(slotCtrl[i].srcCode) == s) selStrobe = srcVec[s-1];
      end
    end

    assign atLast = (pulseCnt == slotCtrl[i].lastCount);

    always_ff @(posedge clk) begin
      if (!rstN || !slotCtrl[i].enable || slotCtrl[i].restart) pulseCnt <= '0;
      else if (selStrobe) pulseCnt <= atLast ? '0 : pulseCnt + 1'b1;
    end

    assign consumerStrobe[i] = slotCtrl[i].enable && selStrobe && atLast;
  end
endmodule

// File: rtl/intsrc_clock_sel.sv
module intsrc_clock_sel
  import intsrc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic               altTable,
  input  logic               auxStrobe,
  input  logic [NUM_GEN-1:0] genStrobe,
  output logic [NUM_SLOTS-1:0] consumerStrobe
);
  logic [USED_W-1:0]         cfgWord;
  slotCtrl_t [NUM_SLOTS-1:0] slotCtrl;

  intsrc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .altTable(altTable), .cfgWord(cfgWord), .slotCtrl(slotCtrl)
  );

  intsrc_datapath u_dp (
    .clk(clk), .rstN(rstN), .slotCtrl(slotCtrl), .auxStrobe(auxStrobe),
    .genStrobe(genStrobe), .consumerStrobe(consumerStrobe)
  );

  assign rdData = {{(REG_W-USED_W){1'b0}}, cfgWord};
endmodule

// File: rtl/intsrc_clock_sel_chk.sv
module intsrc_clock_sel_chk
  import intsrc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [REG_W-1:0]   wrData,
  input logic [REG_W-1:0]   rdData,
  input logic               altTable,
  input logic               auxStrobe,
  input logic [NUM_GEN-1:0] genStrobe,
  input logic [NUM_SLOTS-1:0] consumerStrobe
);
  logic [NUM_IN-1:0] inVec;
  assign inVec = {genStrobe, auxStrobe};

  // R9: upper bits never set
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdData[REG_W-1:USED_W] == '0);

  // R9: a write is visible on the read port next cycle
  p_write_visible_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn) |-> rdData[USED_W-1:0] == $past(wrData[USED_W-1:0]));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
    logic [SRC_W-1:0] code;
    logic [IDX_W-1:0] idx;
    logic             selIn;
    assign code  = rdData[FIELD_W*i+IDX_W +: SRC_W];
    assign idx   = rdData[FIELD_W*i +: IDX_W];
    assign selIn = (code == '0) ? 1'b0 : inVec[code-1'b1];

    // R5: disabled consumer is silent
    p_disabled_low_r5: assert property (@(posedge clk) disable iff (!rstN)
      (code == '0) |-> !consumerStrobe[i]);

    // R6: divide-by-1 follows the selected input
    p_div1_pass_r6: assert property (@(posedge clk) disable iff (!rstN)
      (code != '0 && idx == 2'd0) |-> consumerStrobe[i] == selIn);

    // R7: no output without a selected input pulse
    p_needs_input_r7: assert property (@(posedge clk) disable iff (!rstN)
      consumerStrobe[i] |-> selIn);

    // R7: divide-by-4 never fires on consecutive cycles under stable settings
    p_div4_spacing_r7: assert property (@(posedge clk) disable iff (!rstN)
      ($past(consumerStrobe[i]) && idx == 2'd1 && $stable(rdData) && $stable(altTable))
        |-> !consumerStrobe[i]);
  end
endmodule

bind intsrc_clock_sel intsrc_clock_sel_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .altTable(altTable), .auxStrobe(auxStrobe), .genStrobe(genStrobe),
  .consumerStrobe(consumerStrobe)
);

// File: tb/intsrc_clock_sel_bench.sv
module intsrc_clock_sel_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        altTable = 1'b0;
  logic        auxStrobe = 1'b0;
  logic [5:0]  genStrobe = '0;
  logic [5:0]  consumerStrobe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intsrc_clock_sel u_intsrc_clock_sel (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .altTable(altTable), .auxStrobe(auxStrobe), .genStrobe(genStrobe),
    .consumerStrobe(consumerStrobe)
  );

  // directed layout vectors: consumer, source code, table index, variant, divisor
  localparam int NV = 8;
  localparam int V_CONS[NV] = '{0, 1, 2, 3, 4, 5, 3, 5};
  localparam int V_SRC [NV] = '{1, 2, 3, 4, 5, 6, 7, 1};
  localparam int V_IDX [NV] = '{0, 1, 2, 3, 2, 1, 2, 3};
  localparam int V_ALT [NV] = '{0, 0, 0, 1, 1, 1, 0, 0};
  localparam int V_DIV [NV] = '{1, 4, 1, 2, 3, 4, 1, 2};
  localparam int WIN = 84;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expDiv(input int idx, input int alt);
    case (idx)
      0: return 1;
      1: return 4;
      2: return alt ? 3 : 1;
      default: return 2;
    endcase
  endfunction

  task automatic setSources(input int t);
    auxStrobe = (t % 1) == 0;
    for (int g = 0; g < 6; g++) genStrobe[g] = (t % (g + 2)) == 0;
  endtask

  // clear, write one field, run a window, compare pulse counts
  task automatic runVec(input int cons, input int src, input int idx, input int alt,
                        input int div, input string req);
    int outCnt[6];
    int inCnt;
    @(negedge clk);
    wrEn = 1'b1; wrData = '0; altTable = alt[0];
    auxStrobe = 1'b0; genStrobe = '0;
    @(negedge clk);
    wrData = 32'(((src << 2) | idx) << (5 * cons));
    @(negedge clk);
    wrEn = 1'b0;
    for (int c = 0; c < 6; c++) outCnt[c] = 0;
    inCnt = 0;
    for (int t = 0; t < WIN; t++) begin
      setSources(t);
      #1;
      if ((t % src) == 0) inCnt++;
      for (int c = 0; c < 6; c++) outCnt[c] += int'(consumerStrobe[c]);
      @(negedge clk);
    end
    auxStrobe = 1'b0; genStrobe = '0;
    check({req, " R1 R2 count"}, outCnt[cons], inCnt / div);
    for (int c = 0; c < 6; c++)
      if (c != cons) check({req, " R1 R5 other slot silent"}, outCnt[c], 0);
  endtask

  task automatic pulseAux(input int n, output int outs, input int cons);
    outs = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); auxStrobe = 1'b1; #1; outs += int'(consumerStrobe[cons]);
      @(negedge clk); auxStrobe = 1'b0;
    end
  endtask

  initial begin
    int outs;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset config", rdData, 0);
    check("R10 reset outputs", consumerStrobe, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    auxStrobe = 1'b1; genStrobe = '1; #1;
    check("R10 R5 outputs low after reset", consumerStrobe, 0);
    auxStrobe = 1'b0; genStrobe = '0;

    // R9: readback and upper bits
    @(negedge clk); wrEn = 1'b1; wrData = 32'hFFFF_FFFF;
    @(negedge clk); wrEn = 1'b0; #1;
    check("R9 upper bits zero", rdData, 32'h3FFF_FFFF);
    @(negedge clk); wrEn = 1'b1; wrData = 32'h1234_5678;
    @(negedge clk); wrEn = 1'b0; #1;
    check("R9 readback", rdData, 32'h1234_5678 & 32'h3FFF_FFFF);

    // table of directed vectors
    for (int v = 0; v < NV; v++)
      runVec(V_CONS[v], V_SRC[v], V_IDX[v], V_ALT[v], V_DIV[v], "R3 R4 R6 R7 table");

    // every source code, index and variant
    for (int alt = 0; alt < 2; alt++)
      for (int src = 1; src < 8; src++)
        for (int idx = 0; idx < 4; idx++)
          runVec((src + idx + alt) % 6, src, idx, alt, expDiv(idx, alt),
                 alt ? "R4 sweep" : "R3 sweep");

    // R8: write lands with a selected pulse
    @(negedge clk); altTable = 1'b0; wrEn = 1'b1; wrData = 32'(5'b001_01);
    @(negedge clk); wrEn = 1'b0;
    pulseAux(1, outs, 0);
    @(negedge clk); wrEn = 1'b1; wrData = 32'(5'b001_11); auxStrobe = 1'b1; #1;
    check("R8 output in write cycle", consumerStrobe[0], 0);
    @(negedge clk); wrEn = 1'b0; auxStrobe = 1'b0;
    pulseAux(1, outs, 0);
    check("R8 write-cycle pulse not counted", outs, 0);
    pulseAux(1, outs, 0);
    check("R8 R7 second pulse after restart", outs, 1);

    // R8: variant change restarts the count
    @(negedge clk); wrEn = 1'b1; wrData = 32'(5'b001_10); altTable = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    @(negedge clk);
    pulseAux(2, outs, 0);
    check("R8 R4 two of three", outs, 0);
    @(negedge clk); altTable = 1'b0;
    @(negedge clk); altTable = 1'b1;
    @(negedge clk);
    pulseAux(2, outs, 0);
    check("R8 variant change restarts", outs, 0);
    pulseAux(1, outs, 0);
    check("R8 R7 third pulse fires", outs, 1);

    // R5: disabling silences the consumer
    @(negedge clk); wrEn = 1'b1; wrData = '0;
    @(negedge clk); wrEn = 1'b0;
    pulseAux(3, outs, 0);
    check("R5 disabled silent", outs, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule